// File: doc/BRIEF.md
# I2C Master Clock Generator with Wired-AND Synchronization

This block produces the serial clock of an I2C master from a programmable divide of the peripheral clock. The clock line is open-drain: the block only ever pulls SCL low or lets it float. It times both of its phases against the level it actually reads back from the line. As a result, another master or a slave holding SCL low lengthens the low phase. A device that pulls the line low early ends the high phase at once.

The raw SCL pad level first passes through a synchronizer and a glitch filter. The timer then counts the low phase while the block drives the line. It waits until the filtered line is high before it counts the high phase. The block exports a sampling strobe in the middle of each high phase and a data-change strobe on the first cycle of each low phase, for use by a neighbouring shift register. After every ninth completed high phase (eight data bits plus the acknowledge bit), it raises a one-cycle request that the interrupt flag be set. If that flag is still set when the low count runs out, it keeps SCL low until the flag is cleared. When the master-mode enable is low, the block releases the line and stays idle.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `master_en` is low the block never drives SCL low; dropping `master_en` during a low phase releases the line on the next clock cycle.
- R2: `rate_sel` picks the half period H = (BASE_DIV/2) << `rate_sel` peripheral clocks: code 0 gives BASE_DIV clocks per SCL period, and each higher code doubles it, so codes 0 to 3 give 1x, 2x, 4x and 8x.
- R3: Each low phase that is not stretched keeps `scl_pull` high for exactly H cycles, the first of which follows enabling in master mode.
- R4: The high-phase count starts only once the filtered line is high. Without interference the line is released for H + SYNC_STAGES + FILT_LEN + 1 cycles. When another device holds SCL low after release, the block's own high time is measured from the moment the line rises.
- R5: If the filtered line goes low during the high count, `scl_pull` asserts SYNC_STAGES + FILT_LEN + 1 cycles after the line fell and then holds for a fresh full count of H.
- R6: `ack_done` pulses for one cycle on the first cycle of the low phase that follows every ninth completed high phase, counted from master enable; by then nine `smp_stb` and ten `chg_stb` pulses have occurred.
- R7: If `irq_flag` is high when that low count expires, `scl_pull` stays high until `irq_flag` is sampled low and is released on that cycle, so the low phase lasts the longer of H cycles and the flag's hold time plus one.
- R8: SCL pulses shorter than FILT_LEN peripheral clocks after synchronization do not affect the timing; a pulse of FILT_LEN clocks is accepted as a level change.
- R9: `smp_stb` pulses once when the high count reaches H/2; `chg_stb` pulses on the first cycle of every low phase.
- R10: During reset `scl_pull`, `smp_stb`, `chg_stb` and `ack_done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | RATE_W (2) | Divide-ratio code |
| master_en | input | 1 | High in master-transmit or master-receive mode |
| scl_in | input | 1 | Raw SCL level read back from the pad |
| irq_flag | input | 1 | Serial interrupt flag; while set after a byte, the low phase is held |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| smp_stb | output | 1 | Data-sampling strobe, middle of the high phase |
| chg_stb | output | 1 | Data-change strobe, start of the low phase |
| ack_done | output | 1 | Request to set the interrupt flag after the acknowledge bit |

## Verification
The bench builds the block with BASE_DIV set to 16 and keeps the default two-stage synchronizer and three-clock filter. This makes the shortest half period eight clocks, just above the six-clock filter latency, so every divide code from 0 to 3 can be timed exactly in a short run. A wired-AND model of the line lets the bench hold SCL low from outside. With it, the bench checks the extended low phase, the cut-short high phase, rejection of a two-clock glitch against acceptance of a three-clock pulse, and stretching after the acknowledge bit with the flag cleared both late and early.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOW,
      PH_HOLD,
      PH_RISE,
      PH_HIGH
   } scl_phase_e;

   function automatic int unsigned half_max(input int unsigned base_div,
                                            input int unsigned num_rates,
                                            input bit linear);
      if (linear)
         return (base_div / 2) * num_rates;
      else
         return (base_div / 2) << (num_rates - 1);
   endfunction

endpackage

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o
);
   localparam int unsigned FLT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scl_in_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("scl_in_filter: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FLT_W-1:0]       run_q;
   logic                   lvl_q;
   logic                   sync_last;

   assign sync_last = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sync_q <= '1;
      else
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   // a new level is taken only after FILT_LEN consecutive differing samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b1;
         run_q <= '0;
      end else if (sync_last != lvl_q) begin
         if (run_q == FLT_W'(FILT_LEN - 1)) begin
            lvl_q <= sync_last;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end else begin
         run_q <= '0;
      end
   end

   assign level_o = lvl_q;

   // R8: the filtered level only ever moves toward the synchronized sample
   assert_filt_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> ($past(sync_last) == lvl_q));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] lim,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o,
   output logic             mid_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (!last_o)
         cnt_q <= cnt_q + 1'b1;
   end

   // ">=" keeps the phase finite if the limit shrinks mid-count
   assign last_o = (cnt_q >= lim - 1'b1);
   assign mid_o  = (cnt_q == (lim >> 1));
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/scl_bit_counter.sv
module scl_bit_counter #(
   parameter int unsigned BITS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic final_o
);
   localparam int unsigned BIT_W = (BITS > 1) ? $clog2(BITS) : 1;

   if (BITS < 2) begin : g_bad_bits
      $error("scl_bit_counter: BITS must be at least 2");
   end

   logic [BIT_W-1:0] cnt_q;

   assign final_o = (cnt_q == BIT_W'(BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= final_o ? '0 : cnt_q + 1'b1;
   end

   // R6: the bit index never leaves the byte-plus-acknowledge frame
   assert_bitcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= BIT_W'(BITS - 1));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
   parameter int unsigned BASE_DIV    = 64,
   parameter int unsigned NUM_RATES   = 4,
   parameter bit          LINEAR_RATE = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3,
   parameter int unsigned FRAME_BITS  = 9,
   localparam int unsigned RATE_W     = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              master_en,
   input  logic              scl_in,
   input  logic              irq_flag,
   output logic              scl_pull,
   output logic              smp_stb,
   output logic              chg_stb,
   output logic              ack_done
);
   import scl_gen_pkg::*;

   localparam int unsigned HALF_BASE = BASE_DIV / 2;
   localparam int unsigned HALF_MAX  = half_max(BASE_DIV, NUM_RATES, LINEAR_RATE);
   localparam int unsigned CNT_W     = $clog2(HALF_MAX + 1);
   localparam int unsigned LATENCY   = SYNC_STAGES + FILT_LEN + 1;

   if (BASE_DIV % 2 != 0) begin : g_bad_div
      $error("i2c_scl_gen: BASE_DIV must be even");
   end
   if (HALF_BASE <= LATENCY) begin : g_bad_half
      $error("i2c_scl_gen: half period must exceed the line filter latency");
   end
   if (NUM_RATES < 1) begin : g_bad_rates
      $error("i2c_scl_gen: NUM_RATES must be at least 1");
   end

   // ---------------- rate decode ----------------
   logic [RATE_W-1:0] sel_c;
   logic [CNT_W-1:0]  half_lim;

   always_comb begin
      if (int'(rate_sel) > NUM_RATES - 1)
         sel_c = RATE_W'(NUM_RATES - 1);
      else
         sel_c = rate_sel;
   end

   if (LINEAR_RATE) begin : g_rate_lin
      assign half_lim = CNT_W'(HALF_BASE * (int'(sel_c) + 1));
   end else begin : g_rate_pow2
      assign half_lim = CNT_W'(HALF_BASE) << sel_c;
   end

   // ---------------- line filter ----------------
   logic scl_lvl;

   scl_in_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (scl_in),
      .level_o(scl_lvl)
   );

   // ---------------- phase state ----------------
   scl_phase_e       state_q, state_d;
   logic             t_clr, t_last, t_mid;
   logic [CNT_W-1:0] t_cnt;
   logic             hi_end, frame_last, ackph_q;

   always_comb begin
      state_d = state_q;
      if (!master_en) begin
         state_d = PH_IDLE;
      end else begin
         unique case (state_q)
            PH_IDLE: state_d = PH_LOW;
            PH_LOW:  if (t_last) state_d = (ackph_q && irq_flag) ? PH_HOLD : PH_RISE;
            PH_HOLD: if (!irq_flag) state_d = PH_RISE;
            PH_RISE: if (scl_lvl) state_d = PH_HIGH;
            PH_HIGH: if (!scl_lvl || t_last) state_d = PH_LOW;
            default: state_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= PH_IDLE;
      else
         state_q <= state_d;
   end

   assign t_clr  = (state_d != state_q);
   assign hi_end = (state_q == PH_HIGH) && (state_d == PH_LOW);

   scl_phase_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (t_clr),
      .lim   (half_lim),
      .cnt_o (t_cnt),
      .last_o(t_last),
      .mid_o (t_mid)
   );

   scl_bit_counter #(
      .BITS(FRAME_BITS)
   ) u_bits (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state_q == PH_IDLE),
      .step   (hi_end),
      .final_o(frame_last)
   );

   // marks the low phase that follows the acknowledge bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ackph_q <= 1'b0;
      else if (hi_end)
         ackph_q <= frame_last;
      else if (state_q != PH_LOW)
         ackph_q <= 1'b0;
   end

   // ---------------- outputs ----------------
   assign scl_pull = (state_q == PH_LOW) || (state_q == PH_HOLD);
   assign chg_stb  = (state_q == PH_LOW) && (t_cnt == '0);
   assign smp_stb  = (state_q == PH_HIGH) && t_mid;
   assign ack_done = chg_stb && ackph_q;

   // ---------------- assertions ----------------
   // R1: slave mode releases the clock line on the following cycle
   assert_slave_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !scl_pull);

   // R9: the change strobe only appears while the block drives the line low
   assert_chg_in_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |-> scl_pull);

   // R9: the sampling strobe needs a released line that reads high
   assert_smp_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (!scl_pull && scl_lvl));

   // R6: the acknowledge request is a single-cycle pulse
   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |=> !ack_done);

   // R7: a held low phase persists while the flag stays set
   assert_hold_while_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_HOLD && irq_flag && master_en) |=> scl_pull);

   // R4: the high count only begins from a line seen high
   assert_high_from_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_RISE && state_d == PH_HIGH) |-> scl_lvl);

endmodule

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 16;
   localparam int LAT        = 6;

   // rate code, expected low cycles, expected released cycles
   localparam int VEC [4][3] = '{
      '{0,  8,  8 + LAT},
      '{1, 16, 16 + LAT},
      '{2, 32, 32 + LAT},
      '{3, 64, 64 + LAT}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = '0;
   logic       master_en = 1'b0;
   logic       irq_flag = 1'b0;
   logic       other_low = 1'b0;
   logic       scl_line;
   logic       scl_pull, smp_stb, chg_stb, ack_done;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign scl_line = ~(scl_pull | other_low);

   i2c_scl_gen #(.BASE_DIV(BASE)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .master_en(master_en),
      .scl_in   (scl_line),
      .irq_flag (irq_flag),
      .scl_pull (scl_pull),
      .smp_stb  (smp_stb),
      .chg_stb  (chg_stb),
      .ack_done (ack_done)
   );

   int smp_total = 0;
   int chg_total = 0;
   always @(posedge clk) begin
      smp_total <= smp_total + int'(smp_stb);
      chg_total <= chg_total + int'(chg_stb);
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pull(input logic lvl);
      while (scl_pull != lvl) @(negedge clk);
   endtask

   task automatic count_pull(input logic lvl, output int n);
      n = 0;
      while (scl_pull == lvl) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic restart(input logic [1:0] rs);
      master_en = 1'b0;
      irq_flag  = 1'b0;
      other_low = 1'b0;
      repeat (8) @(negedge clk);
      rate_sel  = rs;
      master_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      int n, s0, c0, ns, nc;
      repeat (4) @(negedge clk);
      // R10: reset state
      chk("R10 pull in reset", int'(scl_pull), 0);
      chk("R10 strobes in reset", int'(smp_stb | chg_stb | ack_done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R9: table walk over all divide codes
      for (int i = 0; i < 4; i++) begin
         restart(2'(VEC[i][0]));
         c0 = chg_total;
         wait_pull(1'b1);
         count_pull(1'b1, n);
         chk($sformatf("R2 R3 low length code %0d", VEC[i][0]), n, VEC[i][1]);
         s0 = smp_total;
         count_pull(1'b0, n);
         chk($sformatf("R4 release length code %0d", VEC[i][0]), n, VEC[i][2]);
         chk($sformatf("R9 one sample strobe code %0d", VEC[i][0]), smp_total - s0, 1);
      end
      chk("R9 change strobes per low", chg_total - c0, 1);

      // R1: slave mode never drives, even with line activity
      master_en = 1'b0;
      n = 0;
      for (int k = 0; k < 60; k++) begin
         other_low = (k % 7) < 3;
         @(negedge clk);
         n += int'(scl_pull);
      end
      other_low = 1'b0;
      chk("R1 no drive in slave mode", n, 0);
      restart(2'd0);
      wait_pull(1'b1);
      master_en = 1'b0;
      @(negedge clk);
      chk("R1 release after mode exit", int'(scl_pull), 0);

      // R4: another device holds the line low well beyond our low phase
      restart(2'd0);
      wait_pull(1'b1);
      other_low = 1'b1;
      repeat (30) @(negedge clk);
      chk("R4 own low done first", int'(scl_pull), 0);
      other_low = 1'b0;
      count_pull(1'b0, n);
      chk("R4 high counted from line rise", n, 8 + LAT);

      // R5: another device pulls low during our high count
      restart(2'd1);
      wait_pull(1'b1);
      wait_pull(1'b0);
      repeat (10) @(negedge clk);
      other_low = 1'b1;
      count_pull(1'b0, n);
      other_low = 1'b0;
      chk("R5 pull follows early low", n, LAT);
      count_pull(1'b1, n);
      chk("R5 fresh low count", n, 16);

      // R8: two-clock glitch ignored, three-clock pulse accepted
      restart(2'd1);
      wait_pull(1'b1);
      wait_pull(1'b0);
      n = 0;
      while (scl_pull == 1'b0) begin
         n++;
         if (n == 11) other_low = 1'b1;
         if (n == 13) other_low = 1'b0;
         @(negedge clk);
      end
      chk("R8 short glitch ignored", n, 16 + LAT);
      count_pull(1'b1, n);
      n = 0;
      while (scl_pull == 1'b0) begin
         n++;
         if (n == 11) other_low = 1'b1;
         if (n == 14) other_low = 1'b0;
         @(negedge clk);
      end
      chk("R8 full-length pulse accepted", n, 10 + LAT);

      // R6 R7: acknowledge request and stretch, flag cleared late
      restart(2'd0);
      ns = 0;
      nc = int'(chg_stb);
      while (!ack_done) begin
         @(negedge clk);
         ns += int'(smp_stb);
         nc += int'(chg_stb);
      end
      chk("R6 samples before ack request", ns, 9);
      chk("R6 low phases up to ack request", nc, 10);
      irq_flag = 1'b1;
      n = 0;
      while (scl_pull) begin
         n++;
         if (n == 41) irq_flag = 1'b0;
         @(negedge clk);
      end
      chk("R7 stretch until flag clear", n, 41);

      // R6 R7: next byte, flag cleared before the low count ends
      ns = 0;
      while (!ack_done) begin
         @(negedge clk);
         ns += int'(smp_stb);
      end
      chk("R6 nine samples in second byte", ns, 9);
      irq_flag = 1'b1;
      n = 0;
      while (scl_pull) begin
         n++;
         if (n == 3) irq_flag = 1'b0;
         @(negedge clk);
      end
      chk("R7 early clear keeps plain low", n, 8);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule